// File: doc/BRIEF.md
# Video Clock Output Divider with Source Routing

This block forms the video clock output of a two-channel clock generator. Each oscillator is modelled as a digital level that is sampled by the system clock. A 3-bit divisor code selects a power-of-two output divisor from 1 to 128. A 4-bit index code can do one of two things. It can gate the video output off. Or it can steer the main oscillator onto the video path in place of the video oscillator, so that both outputs come from one oscillator. In both of those cases the block also requests that the idle video oscillator be powered down.

Requested codes are not applied at once. They are copied into an active configuration only while the divided output is low. A high phase that has already started always runs to its full length, so a code change never produces a runt pulse. Divisor 1 passes the selected source level straight through. It passes through one register, so it appears one system-clock cycle later. Higher divisors count rising edges of the selected source and toggle the output, which gives a 50% duty cycle.

Top module: `vclk_out_div`

## Requirements
- R1: Divisor code k (0 to 7) selects a divisor of 2^k. For k of 1 or more, the output period equals 2^k periods of the selected source.
- R2: With divisor code 0, the output equals the selected source level one system-clock cycle later.
- R3: For divisor codes 1 to 7, the output is high and low for equal lengths of 2^(k-1) source periods each. The output changes only on a counted source rising edge or on a configuration load.
- R4: Index code 4'b1110 holds the output low and asserts the power-down request.
- R5: Index code 4'b1111 routes the main source through the selected divisor to the output and asserts the power-down request.
- R6: Every other index code leaves the video source on the output and keeps the power-down request low.
- R7: New divisor and index codes are applied only while the output is low. A high phase in progress keeps its old length, and the power-down request follows the applied code, not the requested one.
- R8: Reset drives the output low, the power-down request low, and the divider count to zero. It also applies divisor code 0 and index code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples both oscillator levels |
| rst_n | input | 1 | Active-low synchronous reset |
| main_src_i | input | 1 | Main-channel oscillator level |
| vid_src_i | input | 1 | Video-channel oscillator level |
| mux_sel_i | input | 3 | Requested divisor code, divisor = 2^code |
| idx_sel_i | input | 4 | Requested index code (1110 off, 1111 route main) |
| vclk_o | output | 1 | Divided video clock |
| vco_pd_o | output | 1 | Video oscillator power-down request |

## Verification
The two sources run at different periods: 6 cycles for the video source and 8 cycles for the main source. Because of this, a measured high or low time shows both the divisor that was applied and the source that was routed. A directed sweep of all eight divisor codes separates the pass-through path from the counting path. Seeded random pairs of codes then mix the route code with don't-care index values, which separates routing from ignored index bits. The stall and deferral cases need their own directed tests. One changes the codes partway through a long high phase, which shows whether the change waits for the low phase. The other applies the off code and watches that the output stays flat.

// File: rtl/vclk_div_pkg.sv
package vclk_div_pkg;

   typedef enum logic [1:0] {
      VD_OFF  = 2'd0,
      VD_PASS = 2'd1,
      VD_DIV  = 2'd2
   } vd_mode_e;

endpackage

// File: rtl/vdiv_cfg_gate.sv
module vdiv_cfg_gate #(
   parameter int MUX_W = 3,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             out_low_i,
   input  logic [MUX_W-1:0] mux_req_i,
   input  logic [IDX_W-1:0] idx_req_i,
   output logic [MUX_W-1:0] mux_act_o,
   output logic [IDX_W-1:0] idx_act_o,
   output logic             load_o
);

   localparam int CFG_W = MUX_W + IDX_W;

   logic [CFG_W-1:0] req_cfg;
   logic [CFG_W-1:0] act_cfg;

   assign req_cfg = {mux_req_i, idx_req_i};
   assign load_o  = out_low_i && (req_cfg != act_cfg);

   always_ff @(posedge clk) begin
      if (!rst_n)
         act_cfg <= '0;
      else if (load_o)
         act_cfg <= req_cfg;
   end

   assign mux_act_o = act_cfg[CFG_W-1:IDX_W];
   assign idx_act_o = act_cfg[IDX_W-1:0];

   // R7
   cfg_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_cfg) |-> $past(out_low_i));

endmodule

// File: rtl/vdiv_src_sel.sv
module vdiv_src_sel #(
   parameter int                IDX_W      = 4,
   parameter logic [IDX_W-1:0]  ROUTE_CODE = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx_act_i,
   input  logic             main_src_i,
   input  logic             vid_src_i,
   output logic             src_lvl_o,
   output logic             src_rise_o
);

   logic src_q;

   assign src_lvl_o = (idx_act_i == ROUTE_CODE) ? main_src_i : vid_src_i;

   always_ff @(posedge clk) begin
      if (!rst_n)
         src_q <= 1'b0;
      else
         src_q <= src_lvl_o;
   end

   assign src_rise_o = src_lvl_o & ~src_q;

endmodule

// File: rtl/vdiv_pow2.sv
module vdiv_pow2
   import vclk_div_pkg::*;
#(
   parameter int MUX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  vd_mode_e         mode_i,
   input  logic [MUX_W-1:0] mux_act_i,
   input  logic             src_lvl_i,
   input  logic             src_rise_i,
   input  logic             clear_i,
   output logic             clk_o
);

   localparam int CNT_W = (1 << MUX_W) - 1;

   generate
      if (MUX_W < 1 || MUX_W > 5) begin : g_bad_width
         $error("vdiv_pow2: MUX_W out of supported range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] tgt;
   logic             out_q;

   always_comb begin
      tgt = '0;
      if (mux_act_i != '0)
         tgt = (CNT_W'(1) << (mux_act_i - MUX_W'(1))) - CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         out_q <= 1'b0;
      end else begin
         case (mode_i)
            VD_OFF: begin
               cnt_q <= '0;
               out_q <= 1'b0;
            end
            VD_PASS: begin
               cnt_q <= '0;
               out_q <= src_lvl_i;
            end
            default: begin
               if (clear_i)
                  cnt_q <= '0;
               else if (src_rise_i) begin
                  if (cnt_q == tgt) begin
                     cnt_q <= '0;
                     out_q <= ~out_q;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
         endcase
      end
   end

   assign clk_o = out_q;

   // R3
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == VD_DIV) |-> (cnt_q <= tgt));

   // R3
   div_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == VD_DIV && !src_rise_i) |=> $stable(clk_o));

   // R4
   off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == VD_OFF) |=> !clk_o);

endmodule

// File: rtl/vclk_out_div.sv
module vclk_out_div
   import vclk_div_pkg::*;
#(
   parameter int               MUX_W      = 3,
   parameter int               IDX_W      = 4,
   parameter logic [IDX_W-1:0] OFF_CODE   = 4'b1110,
   parameter logic [IDX_W-1:0] ROUTE_CODE = 4'b1111
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             main_src_i,
   input  logic             vid_src_i,
   input  logic [MUX_W-1:0] mux_sel_i,
   input  logic [IDX_W-1:0] idx_sel_i,
   output logic             vclk_o,
   output logic             vco_pd_o
);

   generate
      if (OFF_CODE == ROUTE_CODE) begin : g_bad_codes
         $error("vclk_out_div: OFF_CODE and ROUTE_CODE must differ");
      end
   endgenerate

   logic [MUX_W-1:0] mux_act;
   logic [IDX_W-1:0] idx_act;
   logic             cfg_load;
   logic             src_lvl;
   logic             src_rise;
   logic             div_out;
   vd_mode_e         mode;

   vdiv_cfg_gate #(.MUX_W(MUX_W), .IDX_W(IDX_W)) cfg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .out_low_i (!div_out),
      .mux_req_i (mux_sel_i),
      .idx_req_i (idx_sel_i),
      .mux_act_o (mux_act),
      .idx_act_o (idx_act),
      .load_o    (cfg_load)
   );

   vdiv_src_sel #(.IDX_W(IDX_W), .ROUTE_CODE(ROUTE_CODE)) sel_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx_act_i  (idx_act),
      .main_src_i (main_src_i),
      .vid_src_i  (vid_src_i),
      .src_lvl_o  (src_lvl),
      .src_rise_o (src_rise)
   );

   always_comb begin
      if (idx_act == OFF_CODE)
         mode = VD_OFF;
      else if (mux_act == '0)
         mode = VD_PASS;
      else
         mode = VD_DIV;
   end

   vdiv_pow2 #(.MUX_W(MUX_W)) div_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode),
      .mux_act_i  (mux_act),
      .src_lvl_i  (src_lvl),
      .src_rise_i (src_rise),
      .clear_i    (cfg_load),
      .clk_o      (div_out)
   );

   assign vclk_o   = div_out;
   assign vco_pd_o = (idx_act == OFF_CODE) || (idx_act == ROUTE_CODE);

   // R4
   pd_follows_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vco_pd_o && !vclk_o && (idx_sel_i == OFF_CODE)) |=> !vclk_o);

endmodule

// File: tb/vclk_out_div_tb_top.sv
module vclk_out_div_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       main_src = 1'b0;
   logic       vid_src = 1'b0;
   logic [2:0] mux_sel = 3'd0;
   logic [3:0] idx_sel = 4'd0;
   logic       vclk_o;
   logic       vco_pd_o;

   int checks = 0;
   int errors = 0;
   int vcnt = 0;
   int mcnt = 0;

   localparam int VID_HALF  = 3;
   localparam int MAIN_HALF = 4;

   always #4 clk = ~clk;

   vclk_out_div dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .main_src_i (main_src),
      .vid_src_i  (vid_src),
      .mux_sel_i  (mux_sel),
      .idx_sel_i  (idx_sel),
      .vclk_o     (vclk_o),
      .vco_pd_o   (vco_pd_o)
   );

   always @(negedge clk) begin
      if (vcnt == VID_HALF - 1) begin vcnt <= 0; vid_src <= ~vid_src; end
      else vcnt <= vcnt + 1;
      if (mcnt == MAIN_HALF - 1) begin mcnt <= 0; main_src <= ~main_src; end
      else mcnt <= mcnt + 1;
   end

   function automatic int exp_half(int m, int ix);
      int p;
      p = (ix == 15) ? 2 * MAIN_HALF : 2 * VID_HALF;
      if (m == 0) return p / 2;
      return (1 << (m - 1)) * p;
   endfunction

   function automatic logic exp_pd(int ix);
      return (ix == 14) || (ix == 15);
   endfunction

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic smp();
      @(posedge clk);
      #2;
   endtask

   task automatic set_cfg(input int m, input int ix);
      @(negedge clk);
      mux_sel = 3'(m);
      idx_sel = 4'(ix);
   endtask

   task automatic measure(output int hi, output int lo);
      int g;
      g = 0;
      while (vclk_o !== 1'b0 && g < 4000) begin smp(); g++; end
      g = 0;
      while (vclk_o !== 1'b1 && g < 4000) begin smp(); g++; end
      hi = 0;
      while (vclk_o === 1'b1 && hi < 4000) begin smp(); hi++; end
      lo = 0;
      while (vclk_o === 1'b0 && lo < 4000) begin smp(); lo++; end
   endtask

   task automatic run_case(input int m, input int ix, input string req);
      int hi, lo, e;
      set_cfg(m, ix);
      measure(hi, lo);
      measure(hi, lo);
      e = exp_half(m, ix);
      chk(hi == e, {req, " high time"}, hi, e);
      chk(lo == e, {req, " low time"}, lo, e);
      chk(vco_pd_o == exp_pd(ix), {req, " power-down"}, int'(vco_pd_o), int'(exp_pd(ix)));
   endtask

   initial begin
      #(190000 * 8);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int hi, lo, cnt, highs, pd_bad, r, m, ix;
      r = $urandom(32'd20240611);
      repeat (4) smp();
      // R8 reset state
      chk(vclk_o === 1'b0, "R8 output low in reset", int'(vclk_o), 0);
      chk(vco_pd_o === 1'b0, "R8 power-down low in reset", int'(vco_pd_o), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 pass-through follows video source with one cycle delay
      repeat (3) smp();
      cnt = 0;
      for (int i = 0; i < 40; i++) begin
         smp();
         if (vclk_o !== vid_src) cnt++;
      end
      chk(cnt == 0, "R2 pass-through mismatches", cnt, 0);

      // R1 sweep of all divisor codes on the video source
      for (int k = 0; k < 8; k++) run_case(k, 0, "R1 sweep");

      // R5 route main source, R3 duty
      run_case(3, 15, "R5 route main");
      run_case(0, 15, "R5 route main pass");

      // R4 off code
      set_cfg(3, 14);
      repeat (600) smp();
      highs = 0;
      for (int i = 0; i < 200; i++) begin
         smp();
         if (vclk_o !== 1'b0) highs++;
      end
      chk(highs == 0, "R4 high samples while off", highs, 0);
      chk(vco_pd_o === 1'b1, "R4 power-down while off", int'(vco_pd_o), 1);

      // R6 don't-care index values
      run_case(2, 5, "R6 index 0101");
      run_case(1, 13, "R6 index 1101");

      // R7 change mid high phase
      run_case(4, 0, "R7 setup");
      while (vclk_o !== 1'b0) smp();
      while (vclk_o !== 1'b1) smp();
      cnt = 1;
      for (int i = 0; i < 4; i++) begin
         smp();
         if (vclk_o === 1'b1) cnt++;
      end
      set_cfg(1, 15);
      pd_bad = 0;
      forever begin
         smp();
         if (vclk_o !== 1'b1) break;
         cnt++;
         if (vco_pd_o !== 1'b0) pd_bad++;
      end
      chk(cnt == exp_half(4, 0), "R7 high phase kept old length", cnt, exp_half(4, 0));
      chk(pd_bad == 0, "R7 power-down held during high phase", pd_bad, 0);
      measure(hi, lo);
      measure(hi, lo);
      chk(hi == exp_half(1, 15), "R7 new setting applied", hi, exp_half(1, 15));
      chk(vco_pd_o === 1'b1, "R7 power-down after apply", int'(vco_pd_o), 1);

      // R1 R3 R5 R6 seeded random mix
      for (int t = 0; t < 12; t++) begin
         m = int'($urandom % 8);
         case ($urandom % 3)
            0: ix = 15;
            default: begin
               ix = int'($urandom % 14);
            end
         endcase
         run_case(m, ix, "R3 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule